// File: doc/BRIEF.md
# Sequential Floating-Point Adder with Single-Step Shifters

This block adds two 32-bit floating-point words in a fixed number of clocks. A word holds a sign bit, an 8-bit exponent and a 23-bit fraction. The exponent is stored in excess-128 form, and a leading one is implied above the fraction. There is no subtract operation. To form a difference, the caller inverts bit 31 of the second operand before issuing the request.

A request starts in state `ST_IDLE`. When `req` is sampled high there, the operands are captured and the block moves through three states:

- `ST_ALIGN` orders the two operands by magnitude and right-shifts the smaller significand in one barrel-shift step.
- `ST_SUM` adds or subtracts the two magnitudes, depending on the signs.
- `ST_NORM` renormalizes in one step, using a leading-zero count, a barrel shift and saturation, then packs the word.

The block then enters `ST_DONE`. There it raises `done` and holds the result until `req` is sampled low, which returns it to `ST_IDLE`. Every other state advances unconditionally. The latency does not depend on the exponent difference.

Top module: `fpa_add_seq`

## Requirements
- R1: Word layout. Bit 31 is the sign, bits 30:23 are the exponent e and bits 22:0 are the fraction f. When e is 0 the word means zero, whatever f holds. Otherwise the value is (-1)^sign · 1.f · 2^(e-128).
- R2: When `req` is sampled high in the idle state, the operands are captured. `done` then rises on the fourth rising clock edge, counting that capturing edge, for any pair of operands.
- R3: While `req` stays high, `done` stays high and `res` does not change. One edge after `req` is sampled low, `done` is low and the block is idle.
- R4: The operand with the smaller {exponent, fraction} value is right-shifted by the exponent difference, and bits shifted out are dropped. If the difference is 24 or more, that operand contributes zero.
- R5: With equal signs the magnitudes are added. A carry out of the 24-bit significand shifts the sum right by one, dropping its lowest bit, and raises the exponent by one.
- R6: With unequal signs the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. The difference is then left-shifted by its leading-zero count, and that count is taken off the exponent.
- R7: A zero magnitude sum yields 32'h0000_0000. This covers exact cancellation and zero plus zero of either sign.
- R8: If the result exponent would exceed 255, the result is the operand sign with exponent 8'hFF and fraction 23'h7F_FFFF.
- R9: If the result exponent would fall below 1, the result is 32'h0000_0000.
- R10: After reset, `done` is 0 and `res` is 32'h0000_0000. Subtraction is obtained by adding an operand with bit 31 inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Operation request, four-phase handshake |
| opa | input | 32 | First addend |
| opb | input | 32 | Second addend (invert bit 31 to subtract) |
| done | output | 1 | Result valid; held until req falls |
| res | output | 32 | Packed sum |

## Verification
The state sequence is linear, so a stuck or skipped state shows at the ports immediately. It appears as `done` rising earlier or later than the fourth edge, or not falling one edge after `req` drops. A wrong alignment, sign choice or leading-zero count corrupts `res` on the same edge that `done` rises. Such faults show up most clearly in near-cancellation cases and in exponent differences of 23, 24 and more. Faults in saturation and underflow handling show only at the exponent extremes, so those cases are applied directly rather than left to random stimulus.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int WORD_W    = 1 + EXP_W + MAN_W;
    localparam int SIG_W     = MAN_W + 1;
    localparam int SUM_W     = SIG_W + 1;
    localparam int SH_W      = $clog2(SIG_W + 1);
    localparam int EXT_EXP_W = EXP_W + 2;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_SUM,
        ST_NORM,
        ST_DONE
    } fsm_t;

    // Number of zero bits above the most significant one.
    function automatic logic [SH_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
        logic [SH_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
(
    input  fp_word_t         op_a,
    input  fp_word_t         op_b,
    output logic [SIG_W-1:0] big_sig,
    output logic [SIG_W-1:0] small_sig,
    output logic [EXP_W-1:0] big_exp,
    output logic             sign_out,
    output logic             sub_mode
);

    fp_word_t         lg;
    fp_word_t         sm;
    logic             a_first;
    logic [EXP_W-1:0] gap;
    logic             too_far;
    logic [SIG_W-1:0] sm_sig;
    logic [SIG_W-1:0] stg [SH_W+1];

    // R4: magnitude order on exponent then fraction
    always_comb begin
        a_first = ({op_a.exp, op_a.man} >= {op_b.exp, op_b.man});
        lg      = a_first ? op_a : op_b;
        sm      = a_first ? op_b : op_a;
    end

    always_comb begin
        big_sig  = (lg.exp != '0) ? {1'b1, lg.man} : '0;
        sm_sig   = (sm.exp != '0) ? {1'b1, sm.man} : '0;
        gap      = lg.exp - sm.exp;
        too_far  = (gap >= EXP_W'(SIG_W));
        big_exp  = lg.exp;
        sign_out = lg.sgn;
        sub_mode = lg.sgn ^ sm.sgn;
    end

    // Single-step right barrel shifter, one layer per shift-amount bit
    assign stg[0] = sm_sig;
    for (genvar k = 0; k < SH_W; k++) begin : g_rshift
        assign stg[k+1] = gap[k] ? (stg[k] >> (2**k)) : stg[k];
    end

    assign small_sig = too_far ? '0 : stg[SH_W];

endmodule

// File: rtl/fpa_mag_sum.sv
module fpa_mag_sum
    import fpa_pkg::*;
(
    input  logic [SIG_W-1:0] big_sig,
    input  logic [SIG_W-1:0] small_sig,
    input  logic             sub_mode,
    output logic [SUM_W-1:0] sum
);

    logic [SUM_W-1:0] big_x;
    logic [SUM_W-1:0] small_x;

    always_comb begin
        big_x   = {1'b0, big_sig};
        small_x = {1'b0, small_sig};
        // R5 add, R6 subtract smaller from larger (never negative)
        sum     = sub_mode ? (big_x - small_x) : (big_x + small_x);
    end

endmodule

// File: rtl/fpa_renorm.sv
module fpa_renorm
    import fpa_pkg::*;
(
    input  logic [SUM_W-1:0] sum,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             sgn_in,
    output fp_word_t         result
);

    localparam logic signed [EXT_EXP_W-1:0] ONE_W   = EXT_EXP_W'(1);
    localparam logic signed [EXT_EXP_W-1:0] EXP_TOP = EXT_EXP_W'((2**EXP_W) - 1);

    logic                        carry;
    logic [SH_W-1:0]             lz;
    logic [SIG_W-1:0]            lstg [SH_W+1];
    logic [SIG_W-1:0]            norm_sig;
    logic signed [EXT_EXP_W-1:0] e_wide;
    logic signed [EXT_EXP_W-1:0] e_next;

    assign carry = sum[SUM_W-1];
    assign lz    = lead_zeros(sum[SIG_W-1:0]);

    // Single-step left barrel shifter by the leading-zero count
    assign lstg[0] = sum[SIG_W-1:0];
    for (genvar k = 0; k < SH_W; k++) begin : g_lshift
        assign lstg[k+1] = lz[k] ? (lstg[k] << (2**k)) : lstg[k];
    end

    always_comb begin
        norm_sig = carry ? sum[SUM_W-1:1] : lstg[SH_W];
        e_wide   = $signed({{(EXT_EXP_W-EXP_W){1'b0}}, exp_in});
        if (carry) e_next = e_wide + ONE_W;                                   // R5
        else       e_next = e_wide - $signed({{(EXT_EXP_W-SH_W){1'b0}}, lz}); // R6
    end

    always_comb begin
        if (sum == '0) begin
            result = '0;                                                      // R7
        end else if (e_next > EXP_TOP) begin
            result.sgn = sgn_in;                                              // R8
            result.exp = '1;
            result.man = '1;
        end else if (e_next < ONE_W) begin
            result = '0;                                                      // R9
        end else begin
            result.sgn = sgn_in;
            result.exp = e_next[EXP_W-1:0];
            result.man = norm_sig[MAN_W-1:0];
        end
    end

endmodule

// File: rtl/fpa_add_seq.sv
module fpa_add_seq
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              done,
    output logic [WORD_W-1:0] res
);

    fsm_t             state;
    fsm_t             nxt;

    fp_word_t         op_a_q;
    fp_word_t         op_b_q;
    logic [SIG_W-1:0] big_q;
    logic [SIG_W-1:0] small_q;
    logic [EXP_W-1:0] exp_q;
    logic             sign_q;
    logic             sub_q;
    logic [SUM_W-1:0] sum_q;
    logic [EXP_W-1:0] exp2_q;
    logic             sign2_q;
    fp_word_t         res_q;

    logic [SIG_W-1:0] big_c;
    logic [SIG_W-1:0] small_c;
    logic [EXP_W-1:0] exp_c;
    logic             sign_c;
    logic             sub_c;
    logic [SUM_W-1:0] sum_c;
    fp_word_t         res_c;

    // ---------------- datapath stages ----------------
    fpa_align u_align (
        .op_a      (op_a_q),
        .op_b      (op_b_q),
        .big_sig   (big_c),
        .small_sig (small_c),
        .big_exp   (exp_c),
        .sign_out  (sign_c),
        .sub_mode  (sub_c)
    );

    fpa_mag_sum u_sum (
        .big_sig   (big_q),
        .small_sig (small_q),
        .sub_mode  (sub_q),
        .sum       (sum_c)
    );

    fpa_renorm u_norm (
        .sum       (sum_q),
        .exp_in    (exp2_q),
        .sgn_in    (sign2_q),
        .result    (res_c)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // ---------------- transitions ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = req ? ST_ALIGN : ST_IDLE;
            ST_ALIGN: nxt = ST_SUM;
            ST_SUM:   nxt = ST_NORM;
            ST_NORM:  nxt = ST_DONE;
            ST_DONE:  nxt = req ? ST_DONE : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        done = (state == ST_DONE);
        res  = res_q;
    end

    // ---------------- stage registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a_q  <= '0;
            op_b_q  <= '0;
            big_q   <= '0;
            small_q <= '0;
            exp_q   <= '0;
            sign_q  <= 1'b0;
            sub_q   <= 1'b0;
            sum_q   <= '0;
            exp2_q  <= '0;
            sign2_q <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        op_a_q <= opa;
                        op_b_q <= opb;
                    end
                end
                ST_ALIGN: begin
                    big_q   <= big_c;
                    small_q <= small_c;
                    exp_q   <= exp_c;
                    sign_q  <= sign_c;
                    sub_q   <= sub_c;
                end
                ST_SUM: begin
                    sum_q   <= sum_c;
                    exp2_q  <= exp_q;
                    sign2_q <= sign_q;
                end
                ST_NORM: begin
                    res_q   <= res_c;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state, 3) == ST_ALIGN));                       // R2
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> done);                                              // R3
    AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> $stable(res));                                      // R3
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> !done);                                            // R3
    AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (res_q.exp == '0)) |-> (res_q == '0));                       // R7
    AST_SAT_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (res_q.exp == '1) && $rose(done) && (sum_q != '0)
         && sum_q[SUM_W-1] && (exp2_q == '1)) |-> (res_q.man == '1));         // R8

endmodule

// File: tb/fpa_add_seq_tb_top.sv
module fpa_add_seq_tb_top;

    logic        clk;
    logic        rst_n;
    logic        req;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        done;
    logic [31:0] res;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    int cyc      = 0;

    fpa_add_seq dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .opa   (opa),
        .opb   (opb),
        .done  (done),
        .res   (res)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    initial begin
        wait (cyc > 150000);
        miss_cnt++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    // Reference model written from the requirements
    function automatic logic [31:0] ref_add(input logic [31:0] x, input logic [31:0] y);
        logic [31:0] hi;
        logic [31:0] lo;
        int sh, sl, s, d, eh;
        if (x[30:0] >= y[30:0]) begin hi = x; lo = y; end
        else                    begin hi = y; lo = x; end
        sh = (hi[30:23] != 0) ? int'({1'b1, hi[22:0]}) : 0;
        sl = (lo[30:23] != 0) ? int'({1'b1, lo[22:0]}) : 0;
        d  = int'(hi[30:23]) - int'(lo[30:23]);
        sl = (d >= 24) ? 0 : (sl >> d);
        s  = (hi[31] == lo[31]) ? sh + sl : sh - sl;
        if (s == 0) return 32'h0;
        eh = int'(hi[30:23]);
        if (s >= (1 << 24)) begin
            s  = s >> 1;
            eh = eh + 1;
        end else begin
            while (s < (1 << 23)) begin
                s  = s << 1;
                eh = eh - 1;
            end
        end
        if (eh > 255) return {hi[31], 8'hFF, 23'h7FFFFF};
        if (eh < 1)   return 32'h0;
        return {hi[31], eh[7:0], s[22:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        vec_cnt++;
        if (act !== exp_v) begin
            miss_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] exp_v;
        logic [31:0] held;
        int n;
        exp_v = ref_add(a, b);
        @(negedge clk);
        opa = a;
        opb = b;
        req = 1'b1;
        n   = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 20);
        check("R2 latency", 32'(n), 32'd4);
        check(tag, res, exp_v);
        held = res;
        opa  = ~a;
        opb  = ~b;
        repeat (2) @(negedge clk);
        check("R3 done held", {31'b0, done}, 32'd1);
        check("R3 res stable", res, held);
        req = 1'b0;
        @(negedge clk);
        check("R3 done release", {31'b0, done}, 32'd0);
    endtask

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  e;
        int          pick;
        void'($urandom(32'd1234));
        req   = 1'b0;
        opa   = '0;
        opb   = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset done", {31'b0, done}, 32'd0);
        check("R10 reset res", res, 32'h0);

        // Directed corner cases
        run_op(32'h40000000, 32'h40000000, "R5 carry 1+1");
        run_op(32'h40000000, 32'hC0000000, "R7 cancellation");
        run_op(32'h80000000, 32'h80000000, "R7 neg zero plus neg zero");
        run_op(32'h00000000, 32'hC0400000, "R1 zero plus value");
        run_op(32'h7FFFFFFF, 32'h7FFFFFFF, "R8 positive overflow");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, "R8 negative overflow");
        run_op(32'h00800001, 32'h80800000, "R9 underflow");
        run_op(32'h40000000, 32'h32000000, "R4 gap 28");
        run_op(32'h40000000, 32'h34000000, "R4 gap 24");
        run_op(32'h40000000, 32'h34800000, "R4 gap 23");
        run_op(32'h40000000, 32'hC0400000, "R6 sign of larger");
        run_op(32'h40C00000, 32'h40000000 ^ 32'h80000000, "R10 subtract by sign flip");
        run_op(32'h40FFFFFF, 32'hC0FFFFFE, "R6 deep renormalize");

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            a    = $urandom;
            pick = $urandom % 8;
            if (pick == 0) begin
                b = a ^ 32'h80000000;
            end else if (pick < 5) begin
                e = a[30:23] + 8'($urandom % 7) - 8'd3;
                b = {1'($urandom), e, 23'($urandom)};
            end else if (pick == 5) begin
                a = {1'($urandom), 8'hFE + 8'($urandom % 2), 23'($urandom)};
                b = {a[31], 8'hFE + 8'($urandom % 2), 23'($urandom)};
            end else begin
                b = $urandom;
            end
            run_op(a, b, "R4/R5/R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

endmodule